// File: doc/BRIEF.md
# Seven-Channel DMA Register Front End

This block is the programmable face of a seven-channel DMA controller. Software writes a source address, a block-size word and a channel command word for each channel, plus one shared word that holds a four-bit field per channel. Bit 3 of each field is that channel's enable. The block stores these words, returns them on a combinational read port and decides when a transfer may begin. When a command word is written with its go bit set and the channel's enable is also set, the block emits a launch pulse. The pulse lasts one cycle and carries the channel number with its address, block and command values. The transfer engines pick up that pulse, and each reports completion on its own done line, which drops the go bit again.

Channel 5 has no engine behind it. Writes to its three words are dropped, so it reads as zero and can never launch. A command write that sets the go bit while the stored go bit is still set is a restart of a busy channel. The block reports it on a separate diagnostic pulse.

The launch and restart outputs are plain one-cycle strobes with no ready input, so there is no back-pressure. The engine side must accept a launch in the cycle it appears. The register port has no handshake either: a write is taken in every cycle in which `wr_en` is high.

Top module: `dma_regfile`

## Requirements
- R1: After reset the shared enable word reads 0x07654321. Every channel word reads zero, and `launch_valid` and `restart_valid` are low.
- R2: Channel n (0 to 6) has its address word at byte offset 0x80+0x10*n, its block word at +4 and its command word at +8. The enable word is at 0xF0, and all 32 bits of it can be written. Any other offset reads zero and a write to it changes nothing, including offsets with a nonzero low two bits and the fourth slot at +0xC.
- R3: Writes to any of channel 5's words (0xD0, 0xD4, 0xD8) are discarded. Those words keep reading zero, and channel 5 never launches.
- R4: A command write to channel n with bit 24 of the data set, while bit 4*n+3 of the enable word is set, raises `launch_valid` in the next cycle. In that cycle `launch_chan` is n, `launch_addr` and `launch_blk` are channel n's stored words, and `launch_ctrl` is the written data.
- R5: No launch follows a command write when the channel's enable bit is clear, even though the command word is still stored. No launch follows a write to an address word, a block word or the enable word.
- R6: A high `done_i[n]` clears bit 24 of channel n's command word at the next edge. The other bits of that word are left as they were.
- R7: If a command write to channel n and `done_i[n]` fall in the same cycle, the written data is what gets stored, with bit 24 as written.
- R8: A command write with bit 24 set, to a channel whose stored bit 24 is already set, raises `restart_valid` for one cycle in the next cycle, with `restart_chan` = n. This happens whether or not the channel is enabled. A done in the same cycle does not suppress it.
- R9: Each qualifying command write gives exactly one cycle of `launch_valid`. With no further write, the strobe is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| done_i | input | 7 | Per-channel transfer completion |
| launch_valid | output | 1 | One-cycle transfer launch strobe |
| launch_chan | output | 3 | Channel being launched |
| launch_addr | output | 32 | Address word of the launched channel |
| launch_blk | output | 32 | Block word of the launched channel |
| launch_ctrl | output | 32 | Command word as written |
| restart_valid | output | 1 | Go bit re-set on a busy channel |
| restart_chan | output | 3 | Channel of the restart event |

## Verification
Two functions can meet in one cycle: a command write to a channel, and that same channel's done line clearing its go bit. The bench forces this case directly on channel 6. It also lets random traffic hit it, because a done pulse is sometimes raised on the channel being written. The reference model in the bench applies the done clear first and the write second, then predicts the stored word, the launch and the restart from the state before the edge. It judges the outcome through readback and through the launch and restart strobes.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  // word select inside one channel slot
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_BLK  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // log2 of the byte stride between channel slots
  localparam int unsigned SLOT_LG = 4;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned NUM_CH  = 7,
  parameter int unsigned CW      = 3,
  parameter logic [AW-1:0] CH_BASE = 8'h80,
  parameter logic [AW-1:0] EN_OFF  = 8'hF0
) (
  input  logic [AW-1:0] addr,
  output logic          hit_ch,
  output logic [CW-1:0] ch_idx,
  output reg_sel_e      sel,
  output logic          hit_en
);
  logic [AW-1:0] off;
  logic [AW-1:0] slot;
  logic [1:0]    word;
  logic          in_range;

  always_comb begin
    off      = addr - CH_BASE;
    slot     = off >> SLOT_LG;
    word     = off[SLOT_LG-1:2];
    in_range = (addr >= CH_BASE) && (slot < AW'(NUM_CH));
    hit_ch   = in_range && (off[1:0] == 2'b00) && (word != 2'b11);
    ch_idx   = slot[CW-1:0];
    sel      = hit_ch ? reg_sel_e'(word) : SEL_NONE;
    hit_en   = (addr == EN_OFF);
  end
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
  import dma_rf_pkg::*;
#(
  parameter int unsigned DW        = 32,
  parameter int unsigned START_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic          done,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] blk_q,
  output logic [DW-1:0] ctrl_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      blk_q  <= '0;
      ctrl_q <= '0;
    end else begin
      // completion first; a same-cycle command write below overrides it
      if (done) ctrl_q[START_BIT] <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_ADDR: addr_q <= wdata;
          SEL_BLK:  blk_q  <= wdata;
          SEL_CTRL: ctrl_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  // R6: completion drops the go bit when no command write competes
  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(wr && sel == SEL_CTRL)) |=> !ctrl_q[START_BIT]);

  // R7: a command write is stored whole, even against a done
  p_write_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel == SEL_CTRL) |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/dma_rf_launch.sv
module dma_rf_launch #(
  parameter int unsigned DW        = 32,
  parameter int unsigned CW        = 3,
  parameter int unsigned START_BIT = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic [CW-1:0] ch_idx,
  input  logic [DW-1:0] wdata,
  input  logic          en_bit,
  input  logic          busy_bit,
  input  logic [DW-1:0] cur_addr,
  input  logic [DW-1:0] cur_blk,
  output logic          launch_valid,
  output logic [CW-1:0] launch_chan,
  output logic [DW-1:0] launch_addr,
  output logic [DW-1:0] launch_blk,
  output logic [DW-1:0] launch_ctrl,
  output logic          restart_valid,
  output logic [CW-1:0] restart_chan
);
  logic go;
  logic fire;
  logic again;

  always_comb begin
    go    = wr_ctrl && wdata[START_BIT];
    fire  = go && en_bit;
    again = go && busy_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      launch_valid  <= 1'b0;
      launch_chan   <= '0;
      launch_addr   <= '0;
      launch_blk    <= '0;
      launch_ctrl   <= '0;
      restart_valid <= 1'b0;
      restart_chan  <= '0;
    end else begin
      launch_valid  <= fire;
      restart_valid <= again;
      if (fire) begin
        launch_chan <= ch_idx;
        launch_addr <= cur_addr;
        launch_blk  <= cur_blk;
        launch_ctrl <= wdata;
      end
      if (again) restart_chan <= ch_idx;
    end
  end

  // R4: a launched command always carries its go bit
  p_launch_go_r4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> launch_ctrl[START_BIT]);

  // R8: a restart report needs a command write with the go bit in the prior cycle
  p_restart_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_valid |-> $past(wr_ctrl && wdata[START_BIT]));
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int unsigned   NUM_CH    = 7,
  parameter int unsigned   SKIP_CH   = 5,
  parameter int unsigned   DW        = 32,
  parameter int unsigned   AW        = 8,
  parameter int unsigned   START_BIT = 24,
  parameter logic [AW-1:0] CH_BASE   = 8'h80,
  parameter logic [AW-1:0] EN_OFF    = 8'hF0,
  parameter logic [DW-1:0] EN_RESET  = 32'h0765_4321,
  localparam int unsigned  CW        = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [NUM_CH-1:0] done_i,
  output logic              launch_valid,
  output logic [CW-1:0]     launch_chan,
  output logic [DW-1:0]     launch_addr,
  output logic [DW-1:0]     launch_blk,
  output logic [DW-1:0]     launch_ctrl,
  output logic              restart_valid,
  output logic [CW-1:0]     restart_chan
);
  localparam int unsigned EW = CW + 2;

  logic          w_hit_ch, w_hit_en, r_hit_ch, r_hit_en;
  logic [CW-1:0] w_idx, r_idx;
  reg_sel_e      w_sel, r_sel;

  dma_rf_decode #(.AW(AW), .NUM_CH(NUM_CH), .CW(CW), .CH_BASE(CH_BASE), .EN_OFF(EN_OFF))
    u_wdec (.addr(wr_addr), .hit_ch(w_hit_ch), .ch_idx(w_idx), .sel(w_sel), .hit_en(w_hit_en));
  dma_rf_decode #(.AW(AW), .NUM_CH(NUM_CH), .CW(CW), .CH_BASE(CH_BASE), .EN_OFF(EN_OFF))
    u_rdec (.addr(rd_addr), .hit_ch(r_hit_ch), .ch_idx(r_idx), .sel(r_sel), .hit_en(r_hit_en));

  // shared enable word
  logic [DW-1:0] en_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                 en_q <= EN_RESET;
    else if (wr_en && w_hit_en) en_q <= wr_data;
  end

  logic [DW-1:0] addr_q [NUM_CH];
  logic [DW-1:0] blk_q  [NUM_CH];
  logic [DW-1:0] ctrl_q [NUM_CH];
  logic [NUM_CH-1:0] ch_wr;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    if (n == SKIP_CH) begin : g_dead
      assign ch_wr[n] = 1'b0;       // writes to this slot are dropped
    end else begin : g_live
      assign ch_wr[n] = wr_en && w_hit_ch && (w_idx == CW'(n));
    end
    dma_rf_chan #(.DW(DW), .START_BIT(START_BIT)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr(ch_wr[n]), .sel(w_sel), .wdata(wr_data),
      .done(done_i[n]), .addr_q(addr_q[n]), .blk_q(blk_q[n]), .ctrl_q(ctrl_q[n]));
  end

  logic          wr_ctrl;
  logic [EW-1:0] en_pos;
  logic          en_bit;
  always_comb begin
    wr_ctrl = (|ch_wr) && (w_sel == SEL_CTRL);
    en_pos  = {w_idx, 2'b11};
    en_bit  = en_q[en_pos];
  end

  dma_rf_launch #(.DW(DW), .CW(CW), .START_BIT(START_BIT)) u_launch (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .ch_idx(w_idx), .wdata(wr_data),
    .en_bit(en_bit), .busy_bit(ctrl_q[w_idx][START_BIT]),
    .cur_addr(addr_q[w_idx]), .cur_blk(blk_q[w_idx]),
    .launch_valid(launch_valid), .launch_chan(launch_chan), .launch_addr(launch_addr),
    .launch_blk(launch_blk), .launch_ctrl(launch_ctrl),
    .restart_valid(restart_valid), .restart_chan(restart_chan));

  // readback
  always_comb begin
    rd_data = '0;
    if (r_hit_en) rd_data = en_q;
    else if (r_hit_ch) begin
      case (r_sel)
        SEL_ADDR: rd_data = addr_q[r_idx];
        SEL_BLK:  rd_data = blk_q[r_idx];
        SEL_CTRL: rd_data = ctrl_q[r_idx];
        default:  rd_data = '0;
      endcase
    end
  end

  // R3: the dead channel never appears on the launch strobe
  p_skip_no_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |-> (launch_chan != CW'(SKIP_CH)));

  // R5: writes outside a command word are never followed by a launch
  p_data_no_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && w_sel != SEL_CTRL) |-> !launch_valid);

  // R1: strobes are low in the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(!rst_n) |-> (!launch_valid && !restart_valid));
endmodule

// File: tb/dma_regfile_test.sv
`timescale 1ns/1ps
module dma_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [6:0]  done_i = '0;
  logic        launch_valid, restart_valid;
  logic [2:0]  launch_chan, restart_chan;
  logic [31:0] launch_addr, launch_blk, launch_ctrl;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [31:0] m_addr [7];
  logic [31:0] m_blk  [7];
  logic [31:0] m_ctrl [7];
  logic [31:0] m_en;

  always #2.5 clk = ~clk;

  dma_regfile uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .done_i(done_i),
    .launch_valid(launch_valid), .launch_chan(launch_chan), .launch_addr(launch_addr),
    .launch_blk(launch_blk), .launch_ctrl(launch_ctrl),
    .restart_valid(restart_valid), .restart_chan(restart_chan));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected readback from the register map of R2/R3
  function automatic logic [31:0] model_rd(input logic [7:0] a);
    int ch;
    if (a == 8'hF0) return m_en;
    if (a < 8'h80 || a >= 8'hF0 || a[1:0] != 2'b00 || a[3:2] == 2'b11) return '0;
    ch = (int'(a) - 'h80) >> 4;
    case (a[3:2])
      2'd0: return m_addr[ch];
      2'd1: return m_blk[ch];
      default: return m_ctrl[ch];
    endcase
  endfunction

  task automatic rd_chk(input string req, input logic [7:0] a);
    rd_addr = a;
    #1;
    chk(req, rd_data, model_rd(a));
  endtask

  // one bus cycle: write (optional) plus done lines, then check the strobes
  task automatic op(input string req, input bit we, input logic [7:0] a,
                    input logic [31:0] d, input logic [6:0] dn);
    bit exp_l = 0, exp_r = 0, is_ch;
    int ch = 0;
    logic [31:0] ea = '0, eb = '0;
    is_ch = we && a >= 8'h80 && a < 8'hF0 && a[1:0] == 2'b00 && a[3:2] != 2'b11;
    if (is_ch) ch = (int'(a) - 'h80) >> 4;
    if (is_ch && ch != 5 && a[3:2] == 2'd2 && d[24]) begin
      exp_r = m_ctrl[ch][24];
      exp_l = m_en[4*ch+3];
      ea = m_addr[ch];
      eb = m_blk[ch];
    end
    for (int i = 0; i < 7; i++) if (dn[i]) m_ctrl[i][24] = 1'b0;
    if (we && a == 8'hF0) m_en = d;
    if (is_ch && ch != 5) begin
      case (a[3:2])
        2'd0: m_addr[ch] = d;
        2'd1: m_blk[ch] = d;
        default: m_ctrl[ch] = d;
      endcase
    end
    wr_en = we; wr_addr = a; wr_data = d; done_i = dn;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; done_i = '0;
    chk({req, " launch_valid"}, 32'(launch_valid), 32'(exp_l));
    if (exp_l) begin
      chk({req, " launch_chan"}, 32'(launch_chan), 32'(ch));
      chk({req, " launch_addr"}, launch_addr, ea);
      chk({req, " launch_blk"}, launch_blk, eb);
      chk({req, " launch_ctrl"}, launch_ctrl, d);
    end
    chk({req, " restart_valid"}, 32'(restart_valid), 32'(exp_r));
    if (exp_r) chk({req, " restart_chan"}, 32'(restart_chan), 32'(ch));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 7; i++) begin m_addr[i] = '0; m_blk[i] = '0; m_ctrl[i] = '0; end
    m_en = 32'h0765_4321;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 launch_valid", 32'(launch_valid), 32'd0);
    chk("R1 restart_valid", 32'(restart_valid), 32'd0);
    rd_addr = 8'hF0; #1; chk("R1 enable reset", rd_data, 32'h0765_4321);
    for (int i = 0; i < 7; i++)
      for (int s = 0; s < 3; s++) rd_chk("R1 channel word", 8'(8'h80 + 16*i + 4*s));

    // R2/R5: address and block words store, read back, never launch
    op("R5 addr write", 1, 8'hA0, 32'h1234_5678, '0);
    op("R5 blk write", 1, 8'hA4, 32'h0010_0040, '0);
    rd_chk("R2 addr readback", 8'hA0);
    rd_chk("R2 blk readback", 8'hA4);

    // R5: enable bit 11 clear at reset, go bit stored but no launch
    op("R5 disabled ctrl", 1, 8'hA8, 32'h0100_0201, '0);
    rd_chk("R5 ctrl stored", 8'hA8);

    // R2: full enable word writable
    op("R5 enable write", 1, 8'hF0, 32'hFFFF_FFFF, '0);
    rd_chk("R2 enable readback", 8'hF0);

    // R4/R8: enabled go while already busy -> launch and restart
    op("R4 R8 launch ch2", 1, 8'hA8, 32'h0100_0005, '0);
    // R9: strobe lasts one cycle
    op("R9 idle after launch", 0, 8'h00, '0, '0);

    // R6: done clears only bit 24
    op("R6 done ch2", 0, 8'h00, '0, 7'b000_0100);
    rd_chk("R6 ctrl after done", 8'hA8);
    chk("R6 ctrl value", rd_data, 32'h0000_0005);

    // R3: channel 5 writes dropped, no launch
    op("R3 ch5 addr", 1, 8'hD0, 32'hDEAD_BEEF, '0);
    op("R3 ch5 blk", 1, 8'hD4, 32'hCAFE_F00D, '0);
    op("R3 ch5 ctrl", 1, 8'hD8, 32'h0100_0000, '0);
    rd_chk("R3 ch5 addr", 8'hD0);
    rd_chk("R3 ch5 ctrl", 8'hD8);
    chk("R3 ch5 ctrl zero", rd_data, 32'h0);

    // R7: command write and done on channel 6 in the same cycle
    op("R8 ch6 first go", 1, 8'hE8, 32'h0100_0011, '0);
    op("R7 R8 write with done", 1, 8'hE8, 32'h0100_0022, 7'b100_0000);
    rd_chk("R7 ctrl kept", 8'hE8);
    chk("R7 go bit set", 32'(rd_data[24]), 32'd1);

    // R2: unmapped, misaligned and fourth-slot offsets
    op("R2 unmapped write", 1, 8'hFC, 32'hFFFF_FFFF, '0);
    op("R2 fourth slot write", 1, 8'h8C, 32'hFFFF_FFFF, '0);
    rd_chk("R2 unmapped", 8'hFC);
    rd_chk("R2 fourth slot", 8'h8C);
    rd_chk("R2 misaligned", 8'h81);
    chk("R2 misaligned zero", rd_data, 32'h0);

    // random traffic
    for (int k = 0; k < 600; k++) begin
      int r;
      logic [7:0] a;
      logic [31:0] d;
      logic [6:0] dn;
      r = int'($urandom % 23);
      if (r == 22) a = 8'hF0;
      else if (r == 21) a = 8'hFC;
      else a = 8'(8'h80 + 16*(r/3) + 4*(r%3));
      d = $urandom;
      if (a == 8'hF0) d = d | 32'h0888_8888 & $urandom;
      dn = '0;
      if ($urandom % 4 == 0) dn[$urandom % 7] = 1'b1;
      if ($urandom % 5 == 0 && r < 21) dn[r/3] = 1'b1;   // R7 collision
      op("R4 R6 R7 R8 random", ($urandom % 6) != 0, a, d, dn);
      rd_chk("R2 random readback", 8'(8'h80 + 16*($urandom % 7) + 4*($urandom % 3)));
    end
    for (int i = 0; i < 7; i++)
      for (int s = 0; s < 3; s++) rd_chk("R2 R3 final readback", 8'(8'h80 + 16*i + 4*s));
    rd_chk("R2 final enable", 8'hF0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule